// File: doc/BRIEF.md
# Dual-Clock Line Delay Memory

This block holds one scan line of byte-wide samples and replays them on a second, unrelated clock. The write port stores a word and steps its address on every write-clock rising edge where its active-low enable is low. The read port fetches the word at its own address and steps on every read-clock rising edge where its active-low enable is low. No fill level and no flags exist. The distance between input and output is set only by when each port's address counter was last sent back to zero, and by how long either enable was held off.

A word captured on a write edge sits in a one-entry pipeline and lands in the array on the next write edge. A reader must therefore wait until the write clock has ticked once more before that location holds the new word. Releasing both counters from reset together, with both enables held low, gives a delay of exactly one full line. Releasing the read counter later, or parking the read enable, shortens the delay. When reads are disabled, the output is marked undriven through an output-enable flag, which a pad ring turns into a three-state driver.

Top module: `line_delay_mem`

## Requirements
- R1: The array holds DEPTH words (default 5120) of DATA_W bits (default 8). After a write-counter reset, DEPTH enabled writes followed by a read-counter reset and DEPTH enabled reads return every word in write order.
- R2: On a write edge with wr_rst_n high and wr_en_n low, the word on wr_data is captured for the current write address, and the address advances by one.
- R3: On a write edge with wr_rst_n high and wr_en_n high, no word is stored and the write address holds.
- R4: On a write edge with wr_rst_n low, the write address becomes 0 and no word is stored, whatever the level of wr_en_n.
- R5: A word captured on one write edge enters the array on the next write edge, whether or not that edge is enabled. Until that edge, a read of the location returns its previous content.
- R6: On a read edge with rd_rst_n high and rd_en_n low, rd_data takes the word at the read address, and the read address advances by one.
- R7: On a read edge with rd_rst_n high and rd_en_n high, the read address holds and rd_oe goes low. A later enabled read resumes at the held address.
- R8: Every read edge with rd_rst_n low sets the read address to 0 and loads word 0 onto rd_data. The first enabled edge after release shows word 0 again, and the next edge shows word 1.
- R9: Each address counter wraps from DEPTH-1 back to 0.
- R10: With both ports running on unrelated clocks, the read counter reset together with the write counter, and reads held off for a while, the enabled reads reproduce the enabled writes in order, even when both enables are toggled.
- R11: On a read edge with rd_en_n low, rd_oe goes high, and it stays high on the edges that follow while reads remain enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_rst_n | input | 1 | Synchronous write address reset, active low |
| wr_data | input | DATA_W | Word to store |
| rd_clk | input | 1 | Read clock |
| rd_en_n | input | 1 | Read enable, active low |
| rd_rst_n | input | 1 | Synchronous read address reset, active low |
| rd_data | output | DATA_W | Word fetched on the last read or reset edge |
| rd_oe | output | 1 | High when rd_data is driven; low stands for high impedance |

## Verification
The hardest case to reach from the ports is the commit window: the span after a word has been captured, before the following write edge has moved it into the array. With free-running clocks this window lasts less than one write period. The bench therefore steps each clock by hand. It captures a word, stops the write clock, and walks the read port to that location to see the old content. It then issues one disabled write edge and reads the location again to find the new word.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

   // Action a write port takes on one edge
   typedef enum logic [1:0] {
      WR_IDLE = 2'd0,
      WR_PUSH = 2'd1,
      WR_ZERO = 2'd2
   } wr_act_e;

   // Action a read port takes on one edge
   typedef enum logic [1:0] {
      RD_HOLD   = 2'd0,
      RD_STEP   = 2'd1,
      RD_REWIND = 2'd2
   } rd_act_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ldm_addr_step.sv
module ldm_addr_step #(
   parameter int unsigned DEPTH = 5120,
   parameter int unsigned AW    = 13
) (
   input  logic [AW-1:0] cur,
   output logic [AW-1:0] nxt
);
   import ldm_pkg::*;

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if (is_pow2(DEPTH) && (DEPTH == (1 << AW))) begin : g_natural
         // counter width matches the line length, so it rolls over by itself
         assign nxt = cur + 1'b1;
      end else begin : g_compare
         assign nxt = (cur == LAST) ? '0 : cur + 1'b1;
      end
   endgenerate

endmodule

// File: rtl/ldm_wr_ctrl.sv
module ldm_wr_ctrl #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 5120,
   parameter int unsigned AW     = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_n,
   input  logic [DATA_W-1:0] din,
   output logic              commit_en,
   output logic [AW-1:0]     commit_addr,
   output logic [DATA_W-1:0] commit_data,
   output logic [AW-1:0]     addr_o
);
   import ldm_pkg::*;

   wr_act_e           act;
   logic [AW-1:0]     addr_q;
   logic [AW-1:0]     addr_nxt;
   logic              pend_v;
   logic [AW-1:0]     pend_addr;
   logic [DATA_W-1:0] pend_data;

   // reset wins over enable on this port
   always_comb begin
      if (!rst_n)     act = WR_ZERO;
      else if (!en_n) act = WR_PUSH;
      else            act = WR_IDLE;
   end

   ldm_addr_step #(.DEPTH(DEPTH), .AW(AW)) u_step (
      .cur (addr_q),
      .nxt (addr_nxt)
   );

   always_ff @(posedge clk) begin
      unique case (act)
         WR_ZERO: addr_q <= '0;
         WR_PUSH: addr_q <= addr_nxt;
         default: addr_q <= addr_q;
      endcase
   end

   // one-entry pipeline: the array sees the word one write edge later
   always_ff @(posedge clk) begin
      pend_v <= (act == WR_PUSH);
      if (act == WR_PUSH) begin
         pend_addr <= addr_q;
         pend_data <= din;
      end
   end

   assign commit_en   = pend_v;
   assign commit_addr = pend_addr;
   assign commit_data = pend_data;
   assign addr_o      = addr_q;

endmodule

// File: rtl/ldm_rd_ctrl.sv
module ldm_rd_ctrl #(
   parameter int unsigned DEPTH = 5120,
   parameter int unsigned AW    = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_n,
   output logic          fetch_en,
   output logic [AW-1:0] fetch_addr,
   output logic [AW-1:0] addr_o,
   output logic          oe
);
   import ldm_pkg::*;

   rd_act_e       act;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] addr_nxt;

   always_comb begin
      if (!rst_n)     act = RD_REWIND;
      else if (!en_n) act = RD_STEP;
      else            act = RD_HOLD;
   end

   ldm_addr_step #(.DEPTH(DEPTH), .AW(AW)) u_step (
      .cur (addr_q),
      .nxt (addr_nxt)
   );

   always_ff @(posedge clk) begin
      unique case (act)
         RD_REWIND: addr_q <= '0;
         RD_STEP:   addr_q <= addr_nxt;
         default:   addr_q <= addr_q;
      endcase
   end

   always_ff @(posedge clk) begin
      oe <= !en_n;
   end

   // a rewind edge shows word 0 while the reset is held
   assign fetch_en   = (act != RD_HOLD);
   assign fetch_addr = (act == RD_REWIND) ? '0 : addr_q;
   assign addr_o     = addr_q;

endmodule

// File: rtl/ldm_store.sv
module ldm_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 5120,
   parameter int unsigned AW     = 13
) (
   input  logic              wr_clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_clk,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_q
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge rd_clk) begin
      if (rd_en) rd_q <= mem[rd_addr];
   end

endmodule

// File: rtl/line_delay_mem.sv
module line_delay_mem #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 5120
) (
   input  logic              wr_clk,
   input  logic              wr_en_n,
   input  logic              wr_rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_clk,
   input  logic              rd_en_n,
   input  logic              rd_rst_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("line_delay_mem: DATA_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("line_delay_mem: DEPTH must be at least 2");
      end
   endgenerate

   logic              cm_en;
   logic [AW-1:0]     cm_addr;
   logic [DATA_W-1:0] cm_data;
   logic              ft_en;
   logic [AW-1:0]     ft_addr;
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_ptr;

   ldm_wr_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_wr (
      .clk         (wr_clk),
      .rst_n       (wr_rst_n),
      .en_n        (wr_en_n),
      .din         (wr_data),
      .commit_en   (cm_en),
      .commit_addr (cm_addr),
      .commit_data (cm_data),
      .addr_o      (wr_ptr)
   );

   ldm_rd_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
      .clk        (rd_clk),
      .rst_n      (rd_rst_n),
      .en_n       (rd_en_n),
      .fetch_en   (ft_en),
      .fetch_addr (ft_addr),
      .addr_o     (rd_ptr),
      .oe         (rd_oe)
   );

   ldm_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .wr_clk  (wr_clk),
      .wr_en   (cm_en),
      .wr_addr (cm_addr),
      .wr_data (cm_data),
      .rd_clk  (rd_clk),
      .rd_en   (ft_en),
      .rd_addr (ft_addr),
      .rd_q    (rd_data)
   );

endmodule

// File: rtl/ldm_checker.sv
module ldm_checker #(
   parameter int unsigned DEPTH = 5120,
   parameter int unsigned AW    = 13
) (
   input logic          wr_clk,
   input logic          wr_en_n,
   input logic          wr_rst_n,
   input logic          rd_clk,
   input logic          rd_en_n,
   input logic          rd_rst_n,
   input logic          rd_oe,
   input logic [AW-1:0] wr_ptr,
   input logic [AW-1:0] rd_ptr
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   // counters hold no defined value until each port has seen its reset
   logic wr_live = 1'b0;
   logic rd_live = 1'b0;

   always_ff @(posedge wr_clk) if (!wr_rst_n) wr_live <= 1'b1;
   always_ff @(posedge rd_clk) if (!rd_rst_n) rd_live <= 1'b1;

   // R2 R9
   wr_advance_chk: assert property (@(posedge wr_clk) disable iff (!wr_live)
      (wr_rst_n && !wr_en_n) |=>
         wr_ptr == (($past(wr_ptr) == LAST) ? '0 : $past(wr_ptr) + 1'b1));

   // R3
   wr_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_live)
      (wr_rst_n && wr_en_n) |=> $stable(wr_ptr));

   // R4
   wr_zero_chk: assert property (@(posedge wr_clk) disable iff (!wr_live)
      !wr_rst_n |=> (wr_ptr == '0));

   // R6 R9
   rd_advance_chk: assert property (@(posedge rd_clk) disable iff (!rd_live)
      (rd_rst_n && !rd_en_n) |=>
         rd_ptr == (($past(rd_ptr) == LAST) ? '0 : $past(rd_ptr) + 1'b1));

   // R7
   rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_live)
      (rd_rst_n && rd_en_n) |=> ($stable(rd_ptr) && !rd_oe));

   // R8
   rd_zero_chk: assert property (@(posedge rd_clk) disable iff (!rd_live)
      !rd_rst_n |=> (rd_ptr == '0));

   // R11
   rd_drive_chk: assert property (@(posedge rd_clk) disable iff (!rd_live)
      !rd_en_n |=> rd_oe);

endmodule

bind line_delay_mem ldm_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
   .wr_clk   (wr_clk),
   .wr_en_n  (wr_en_n),
   .wr_rst_n (wr_rst_n),
   .rd_clk   (rd_clk),
   .rd_en_n  (rd_en_n),
   .rd_rst_n (rd_rst_n),
   .rd_oe    (rd_oe),
   .wr_ptr   (wr_ptr),
   .rd_ptr   (rd_ptr)
);

// File: tb/test_line_delay_mem.sv
module test_line_delay_mem;

   localparam int DW        = 8;
   localparam int DEPTH     = 5120;
   localparam int WR_PERIOD = 10;
   localparam int RD_PERIOD = 14;

   logic          wr_clk = 1'b0;
   logic          wr_en_n = 1'b1;
   logic          wr_rst_n = 1'b1;
   logic [DW-1:0] wr_data = '0;
   logic          rd_clk = 1'b0;
   logic          rd_en_n = 1'b1;
   logic          rd_rst_n = 1'b1;
   logic [DW-1:0] rd_data;
   logic          rd_oe;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 1'b0;

   logic [DW-1:0] ref_q [$];

   line_delay_mem #(.DATA_W(DW), .DEPTH(DEPTH)) i_line_delay_mem (
      .wr_clk   (wr_clk),
      .wr_en_n  (wr_en_n),
      .wr_rst_n (wr_rst_n),
      .wr_data  (wr_data),
      .rd_clk   (rd_clk),
      .rd_en_n  (rd_en_n),
      .rd_rst_n (rd_rst_n),
      .rd_data  (rd_data),
      .rd_oe    (rd_oe)
   );

   function automatic logic [DW-1:0] pat(input int i);
      return DW'(i * 29 + (i >> 8) + 3);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one write edge; inputs set while the clock is low
   task automatic wr_step(input logic rst_n, input logic en_n, input logic [DW-1:0] d);
      wr_rst_n = rst_n;
      wr_en_n  = en_n;
      wr_data  = d;
      #(WR_PERIOD / 2) wr_clk = 1'b1;
      #(WR_PERIOD / 2) wr_clk = 1'b0;
   endtask

   // one read edge; outputs are sampled by the caller after the falling edge
   task automatic rd_step(input logic rst_n, input logic en_n);
      rd_rst_n = rst_n;
      rd_en_n  = en_n;
      #(RD_PERIOD / 2) rd_clk = 1'b1;
      #(RD_PERIOD / 2) rd_clk = 1'b0;
   endtask

   task automatic t_reset;
      wr_step(1'b0, 1'b1, '0);
      wr_step(1'b0, 1'b1, '0);
      rd_step(1'b0, 1'b1);
      check(rd_oe == 1'b0, "R7 reset/disabled oe", rd_oe, 0);
   endtask

   task automatic t_fill;
      int bad = 0;
      int bad_act = 0;
      int bad_exp = 0;
      wr_step(1'b0, 1'b1, '0);
      for (int i = 0; i < DEPTH; i++) wr_step(1'b1, 1'b0, pat(i));
      wr_step(1'b1, 1'b1, '0);
      rd_step(1'b0, 1'b0);
      check(rd_data == pat(0), "R8 word0 on reset edge", rd_data, pat(0));
      check(rd_oe == 1'b1, "R11 oe with enable", rd_oe, 1);
      for (int i = 0; i < DEPTH; i++) begin
         rd_step(1'b1, 1'b0);
         if (rd_data !== pat(i) && bad == 0) begin
            bad_act = rd_data;
            bad_exp = pat(i);
         end
         if (rd_data !== pat(i)) bad++;
      end
      check(bad == 0, "R1 R2 R6 full line readback", bad_act, bad_exp);
      check(rd_oe == 1'b1, "R11 oe stays high", rd_oe, 1);
      rd_step(1'b1, 1'b0);
      check(rd_data == pat(0), "R9 read wrap", rd_data, pat(0));
   endtask

   task automatic t_wr_wrap;
      wr_step(1'b1, 1'b0, 8'hA5);
      wr_step(1'b1, 1'b1, '0);
      rd_step(1'b0, 1'b0);
      check(rd_data == 8'hA5, "R9 write wrap", rd_data, 8'hA5);
   endtask

   task automatic t_wr_hold;
      repeat (3) wr_step(1'b1, 1'b1, 8'h11);
      wr_step(1'b1, 1'b0, 8'h3C);
      wr_step(1'b1, 1'b1, '0);
      rd_step(1'b0, 1'b0);
      rd_step(1'b1, 1'b0);
      rd_step(1'b1, 1'b0);
      check(rd_data == 8'h3C, "R3 disabled writes ignored", rd_data, 8'h3C);
   endtask

   task automatic t_wr_reset_priority;
      wr_step(1'b0, 1'b0, 8'h77);
      wr_step(1'b1, 1'b0, 8'h5A);
      wr_step(1'b1, 1'b0, 8'h6B);
      wr_step(1'b1, 1'b1, '0);
      rd_step(1'b0, 1'b0);
      rd_step(1'b1, 1'b0);
      check(rd_data == 8'h5A, "R4 word0 after reset", rd_data, 8'h5A);
      rd_step(1'b1, 1'b0);
      check(rd_data == 8'h6B, "R4 word1 after reset", rd_data, 8'h6B);
      rd_step(1'b1, 1'b0);
      check(rd_data == pat(2), "R4 reset edge stored nothing", rd_data, pat(2));
   endtask

   task automatic t_commit;
      wr_step(1'b1, 1'b0, 8'hC3);
      rd_step(1'b0, 1'b0);
      repeat (3) rd_step(1'b1, 1'b0);
      check(rd_data == pat(2), "R5 old word before commit", rd_data, pat(2));
      wr_step(1'b1, 1'b1, '0);
      rd_step(1'b0, 1'b0);
      repeat (3) rd_step(1'b1, 1'b0);
      check(rd_data == 8'hC3, "R5 new word after commit", rd_data, 8'hC3);
   endtask

   task automatic t_rd_hold;
      rd_step(1'b0, 1'b0);
      rd_step(1'b1, 1'b0);
      rd_step(1'b1, 1'b1);
      check(rd_oe == 1'b0, "R7 oe low when disabled", rd_oe, 0);
      rd_step(1'b1, 1'b1);
      rd_step(1'b1, 1'b0);
      check(rd_data == 8'h6B, "R7 resume at held address", rd_data, 8'h6B);
      check(rd_oe == 1'b1, "R11 oe back high", rd_oe, 1);
   endtask

   task automatic t_rd_reset_hold;
      int bad = 0;
      repeat (3) begin
         rd_step(1'b0, 1'b0);
         if (rd_data !== 8'h5A) bad++;
      end
      check(bad == 0, "R8 word0 while reset held", bad, 0);
      rd_step(1'b1, 1'b0);
      check(rd_data == 8'h5A, "R8 word0 after release", rd_data, 8'h5A);
      rd_step(1'b1, 1'b0);
      check(rd_data == 8'h6B, "R8 word1 next", rd_data, 8'h6B);
   endtask

   task automatic t_stream;
      int bad = 0;
      int bad_act = 0;
      int bad_exp = 0;
      int oe_bad = 0;
      ref_q.delete();
      fork
         begin
            wr_step(1'b0, 1'b1, '0);
            for (int j = 0; j < 1000; j++) begin
               logic off;
               off = (j % 7 == 6);
               wr_step(1'b1, off, DW'(j * 13 + 7));
               if (!off) ref_q.push_back(DW'(j * 13 + 7));
            end
         end
         begin
            int got = 0;
            int k = 0;
            rd_step(1'b0, 1'b1);
            repeat (40) begin
               rd_step(1'b1, 1'b1);
               if (rd_oe !== 1'b0) oe_bad++;
            end
            while (got < 600) begin
               logic off;
               off = (k % 5 == 4);
               k++;
               rd_step(1'b1, off);
               if (!off) begin
                  logic [DW-1:0] e;
                  got++;
                  e = (ref_q.size() > 0) ? ref_q.pop_front() : ~rd_data;
                  if (rd_data !== e && bad == 0) begin
                     bad_act = rd_data;
                     bad_exp = e;
                  end
                  if (rd_data !== e) bad++;
               end
            end
         end
      join
      check(oe_bad == 0, "R10 output off while parked", oe_bad, 0);
      check(bad == 0, "R10 delayed stream order", bad_act, bad_exp);
   endtask

   initial begin
      #(3000000);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_fill();
      t_wr_wrap();
      t_wr_hold();
      t_wr_reset_priority();
      t_commit();
      t_rd_hold();
      t_rd_reset_hold();
      t_stream();
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

endmodule